// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 40 level-sensitive interrupt lines into two banks (lines 0 to 31 in the low bank, lines 32 to 39 in bit positions 0 to 7 of the high bank). Each line has an enable bit and a route bit. The route bit sends an active, enabled line to the fast-interrupt output (`fiq_o`) when it is 1, and to the normal-interrupt output (`irq_o`) when it is 0. A separate wake output tells a halted core that something is pending. An idle-control setting decides whether disabled lines can also wake it.

Software reaches the block through a simple word-addressed bus. The bus exposes the raw line state, the filtered pending views for each output, the enable and route words, the idle control and 40 priority slots. A read-only highest-priority word names the first active line of each class in slot order. A separate encoder module computes that word, and the top module instantiates it.

Top module: `dual_bank_intc`

## Requirements
- R1: Line n < 32 is bit n of each low-bank word. Line n >= 32 is bit n-32 of each high-bank word. High-bank enable and route words keep only bits 7:0 and read zero above that.
- R2: The raw pending bit of each line equals the line level sampled at the previous clock edge, with no latching. The raw words (0x10 low, 0xAC high) are read-only.
- R3: `fiq_o` is 1 exactly when some line is pending, enabled and routed (route=1). `irq_o` is 1 exactly when some line is pending, enabled and not routed.
- R4: The normal-pending words (0x00 low, 0x9C high) read pending & enable & ~route. The fast-pending words (0x0C low, 0xA8 high) read pending & enable & route.
- R5: The enable words (0x04, 0xA0) and route words (0x08, 0xA4) are read/write and reset to zero.
- R6: Writing control (0x14) with bit 0 = 1 clears the idle mask. Writing it with bit 0 = 0 sets the idle mask to all ones. Control reads 1 when the idle mask is clear and 0 when it is set. The idle mask is clear after reset.
- R7: `wake_o` is 1 one cycle after `core_halted` is high, while some pending line is enabled or the idle mask is set.
- R8: Priority slots 0 to 31 sit at 0x1C + 4*k and slots 32 to 39 at 0xB0 + 4*(k-32). A write keeps bit 31 (slot valid) and bits 5:0 (line number). All other bits read zero, and slots reset to zero.
- R9: The highest-priority word (0x18) starts as 0x003F003F. Slots are scanned from 0 upward, and only valid slots naming a line below 40 count. The first such slot whose line is a fast request sets bit 15 and puts the line number in bits 5:0. The first such slot whose line is a normal request sets bit 31 and puts the line number in bits 21:16.
- R10: Offsets that are undefined or not word-aligned read zero and ignore writes. Writes to read-only words have no effect.
- R11: A read returns its data on `bus_rdata` on the cycle after the request. `bus_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 40 | Interrupt line levels |
| core_halted | input | 1 | Core is in a halted state |
| bus_valid | input | 1 | Bus request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request to a halted core |

## Verification
A wrong enable or route bit shows on `fiq_o` or `irq_o` one cycle after the offending write or line change. It also shows in the filtered pending words on the next read. A corrupted idle flag appears on `wake_o` while the core is halted, and in the control read. A bad priority slot shows only through the highest-priority word, so the bench sets up competing slots with a mix of fast and normal lines and an invalid line number.

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NSRC = 40,
  parameter int IDW  = 6
) (
  input  logic [NSRC-1:0]     slot_v,
  input  logic [NSRC*IDW-1:0] slot_id,
  input  logic [NSRC-1:0]     act_fast,
  input  logic [NSRC-1:0]     act_norm,
  output logic [31:0]         hp_word
);
  always_comb begin
    hp_word = 32'h003F_003F;
    for (int i = NSRC - 1; i >= 0; i--) begin
      logic [IDW-1:0] id;
      id = slot_id[i*IDW +: IDW];
      if (slot_v[i] && ({26'd0, id} < NSRC)) begin
        if (act_fast[id]) hp_word[15:0] = {1'b1, 9'd0, id};
        if (act_norm[id]) hp_word[31:16] = {1'b1, 9'd0, id};
      end
    end
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
  parameter int NSRC = 40,
  parameter int AW   = 8,
  parameter int IDW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            core_halted,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            fiq_o,
  output logic            irq_o,
  output logic            wake_o
);
  localparam int NHI = NSRC - 32;
  localparam int WW  = AW - 2;
  localparam logic [WW-1:0] W_NPEND0 = 0,  W_EN0 = 1,  W_RT0 = 2,  W_FPEND0 = 3,
                            W_RAW0 = 4,    W_CTRL = 5, W_HP = 6,
                            W_NPEND1 = 39, W_EN1 = 40, W_RT1 = 41, W_FPEND1 = 42, W_RAW1 = 43;

  function automatic logic [WW-1:0] slot_word(input int e);
    return (e < 32) ? WW'(7 + e) : WW'(12 + e);
  endfunction

  logic [NSRC-1:0]     pend, en, rt;
  logic                idle_on, halted_q, past_ok;
  logic [NSRC-1:0]     slot_v;
  logic [NSRC*IDW-1:0] slot_id;
  logic [31:0]         rd_mux, hp_word;
  logic [NSRC-1:0]     act_fast, act_norm;

  wire [WW-1:0] word    = bus_addr[AW-1:2];
  wire          aligned = (bus_addr[1:0] == 2'b00);
  wire          wr      = bus_valid & bus_write & aligned;
  wire          rd      = bus_valid & ~bus_write;

  assign act_fast = pend & en & rt;
  assign act_norm = pend & en & ~rt;
  assign fiq_o    = |act_fast;
  assign irq_o    = |act_norm;
  assign wake_o   = halted_q & |(pend & (en | {NSRC{idle_on}}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; en <= '0; rt <= '0; idle_on <= 1'b0; halted_q <= 1'b0;
      slot_v <= '0; slot_id <= '0; past_ok <= 1'b0;
    end else begin
      pend     <= src;
      halted_q <= core_halted;
      past_ok  <= 1'b1;
      if (wr) begin
        case (word)
          W_EN0:  en[31:0]      <= bus_wdata;
          W_RT0:  rt[31:0]      <= bus_wdata;
          W_EN1:  en[NSRC-1:32] <= bus_wdata[NHI-1:0];
          W_RT1:  rt[NSRC-1:32] <= bus_wdata[NHI-1:0];
          W_CTRL: idle_on       <= ~bus_wdata[0];
          default: ;
        endcase
        for (int e = 0; e < NSRC; e++) begin
          if (word == slot_word(e)) begin
            slot_v[e]             <= bus_wdata[31];
            slot_id[e*IDW +: IDW] <= bus_wdata[IDW-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (word)
        W_NPEND0: rd_mux = act_norm[31:0];
        W_EN0:    rd_mux = en[31:0];
        W_RT0:    rd_mux = rt[31:0];
        W_FPEND0: rd_mux = act_fast[31:0];
        W_RAW0:   rd_mux = pend[31:0];
        W_CTRL:   rd_mux = {31'd0, ~idle_on};
        W_HP:     rd_mux = hp_word;
        W_NPEND1: rd_mux = 32'(act_norm[NSRC-1:32]);
        W_EN1:    rd_mux = 32'(en[NSRC-1:32]);
        W_RT1:    rd_mux = 32'(rt[NSRC-1:32]);
        W_FPEND1: rd_mux = 32'(act_fast[NSRC-1:32]);
        W_RAW1:   rd_mux = 32'(pend[NSRC-1:32]);
        default:  ;
      endcase
      for (int e = 0; e < NSRC; e++)
        if (word == slot_word(e)) rd_mux = {slot_v[e], 25'd0, slot_id[e*IDW +: IDW]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  prio_pick #(.NSRC(NSRC), .IDW(IDW)) u_pick (
    .slot_v(slot_v), .slot_id(slot_id),
    .act_fast(act_fast), .act_norm(act_norm), .hp_word(hp_word)
  );

  // R2
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> pend == $past(src));
  // R7
  wake_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o || irq_o) && halted_q |-> wake_o);
  // R5
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && word == W_EN0 |=> en[31:0] == $past(bus_wdata));
  // R10
  undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && !aligned |=> $stable(en) && $stable(rt) && $stable(idle_on) && $stable(slot_v));
  // R8
  slot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && aligned && word >= 7 && word <= 38 |=> bus_rdata[30:6] == 25'd0);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_dual_bank_intc.sv
module sim_dual_bank_intc;
  logic clk = 0, rst_n = 0;
  logic [39:0] src = '0;
  logic core_halted = 0, bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fiq_o, irq_o, wake_o;
  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit rsp_due = 0;

  always #2 clk = ~clk;

  dual_bank_intc u0 (.clk, .rst_n, .src, .core_halted, .bus_valid, .bus_write,
    .bus_addr, .bus_wdata, .bus_rdata, .fiq_o, .irq_o, .wake_o);

  always @(negedge clk) if (rsp_due) begin
    logic [31:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front(); rsp_due = 0;
    checks++;
    if (bus_rdata !== e) begin
      fails++; $display("FAIL %s rdata=%h exp=%h", t, bus_rdata, e);
    end
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk);
    exp_q.push_back(e); tag_q.push_back(t); rsp_due = 1;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic pins(input logic f, input logic i, input logic w, input string t);
    checks++;
    if ({fiq_o, irq_o, wake_o} !== {f, i, w}) begin
      fails++; $display("FAIL %s fiq/irq/wake=%b%b%b exp=%b%b%b", t, fiq_o, irq_o, wake_o, f, i, w);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; $display("FAIL watchdog");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    pins(0, 0, 0, "R3 reset outputs");
    rd(8'h04, 0, "R5 reset enable");
    rd(8'h10, 0, "R2 reset raw");
    rd(8'h14, 1, "R6 reset control");
    rd(8'h18, 32'h003F003F, "R9 reset highest");
    src[3] = 1; src[35] = 1; tick();
    rd(8'h10, 8, "R2 raw low");
    rd(8'hAC, 8, "R1 raw high bank");
    pins(0, 0, 0, "R3 disabled lines");
    src[3] = 0; tick();
    rd(8'h10, 0, "R2 line dropped");
    src[3] = 1;
    wr(8'h04, 8); wr(8'hA0, 8);
    pins(0, 1, 0, "R3 normal request");
    rd(8'h00, 8, "R4 normal pending low");
    rd(8'h0C, 0, "R4 fast pending low");
    wr(8'hA4, 8);
    pins(1, 1, 0, "R3 fast and normal");
    rd(8'hA8, 8, "R4 fast pending high");
    rd(8'h9C, 0, "R4 normal pending high");
    rd(8'hA4, 8, "R5 route readback");
    wr(8'h04, 0); wr(8'hA0, 0);
    core_halted = 1; tick();
    pins(0, 0, 0, "R7 no wake idle clear");
    wr(8'h14, 0);
    pins(0, 0, 1, "R7 wake via idle");
    rd(8'h14, 0, "R6 idle set");
    wr(8'h14, 1);
    pins(0, 0, 0, "R6 idle cleared");
    core_halted = 0;
    wr(8'h30, 32'hFFFFFFFF);
    rd(8'h30, 32'h8000003F, "R8 slot 5 masking");
    wr(8'hB4, 32'h12345623);
    rd(8'hB4, 32'h00000023, "R8 slot 33 masking");
    src[4] = 1;
    wr(8'h04, 32'h18); wr(8'hA0, 8);
    wr(8'h1C, 32'h80000023); wr(8'h20, 32'h80000003); wr(8'h24, 32'h8000002D);
    rd(8'h18, 32'h80038023, "R9 highest both classes");
    wr(8'h20, 32'h80000004); wr(8'h28, 32'h80000003);
    rd(8'h18, 32'h80048023, "R9 lower slot wins");
    wr(8'hD0, 32'hFFFFFFFF);
    wr(8'h05, 32'h0);
    rd(8'h04, 32'h18, "R10 undefined write ignored");
    rd(8'hD0, 0, "R10 undefined read zero");
    wr(8'h10, 32'hFFFFFFFF);
    rd(8'h10, 32'h18, "R10 raw read-only");
    wr(8'hA0, 32'hFFFFFFFF);
    rd(8'hA0, 32'hFF, "R1 high bank width");
    rd(8'h14, 1, "R11 read before idle");
    tick(); tick();
    checks++;
    if (bus_rdata !== 1) begin fails++; $display("FAIL R11 hold rdata=%h exp=%h", bus_rdata, 32'd1); end
    tick();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule